// File: doc/BRIEF.md
# UART RTS/CTS Flow Control

This block is the hardware-handshake layer that sits between a UART's receiver, its transmitter and the surrounding software and DMA logic. On the receive side it produces the RTS output, which asks the far end to stop sending. RTS goes high when the local receiver is switched off or when the DMA engine signals that the current receive buffer is full. Software hands over a fresh buffer by re-arming the buffer-full flag. That drops RTS and lets the far transmitter carry on.

On the transmit side the block resynchronises the incoming CTS line. While CTS is high it refuses to start a new character. A character that is already being shifted out runs to completion, because the block only gates the start request.

Every level change on CTS sets a sticky change flag. That flag drives an interrupt request through a mask and clears when the status is read. Flow control is applied only when the mode input selects handshaking. In any other mode RTS stays low and CTS does not gate the transmitter.

Top module: `uart_flow_ctrl`

## Requirements
- R1: While reset is active, the buffer-full flag, the CTS-change flag and the interrupt request are all 0 and the receiver is off. With the mode input at 2, RTS is therefore 1.
- R2: When the mode input differs from 2, RTS is 0 and the CTS level has no effect on tx_start_o.
- R3: With the mode input at 2, RTS is 1 whenever the receiver is off.
- R4: A one-cycle pulse on rx_en_cmd_i turns the receiver on and a pulse on rx_dis_cmd_i turns it off. If both pulses arrive in the same cycle, the receiver ends up off.
- R5: A pulse on dma_buf_full_i sets the buffer-full flag (rxbuff_o) and a pulse on buf_rearm_i clears it, with setting taking priority. With the mode input at 2, RTS is 1 while the flag is set. RTS is 0 when the flag is clear and the receiver is on.
- R6: tx_start_o is 1 exactly when tx_req_i is 1, tx_busy_i is 0, and either the mode is not 2 or the synchronised CTS level is 0. A character in progress is never interrupted.
- R7: CTS passes through two flip-flops. A change on cts_i takes effect on tx_start_o after the second following clock edge, and it sets ctsic_o after the third.
- R8: Any change of the synchronised CTS level, rising or falling and in any mode, sets ctsic_o. The flag stays set until it is cleared by a read.
- R9: A status-read pulse (stat_rd_i) clears ctsic_o on the next edge. If a CTS change is detected in the same cycle, the flag stays set.
- R10: irq_o equals ctsic_o AND ctsic_ie_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 4 | Operating mode; the value 2 selects hardware handshaking |
| rx_en_cmd_i | input | 1 | Receiver enable command pulse |
| rx_dis_cmd_i | input | 1 | Receiver disable command pulse |
| dma_buf_full_i | input | 1 | Buffer-full pulse from the DMA side |
| buf_rearm_i | input | 1 | Software pulse that clears the buffer-full flag |
| rts_o | output | 1 | Request-to-send output (high = stop) |
| rxbuff_o | output | 1 | Buffer-full flag |
| cts_i | input | 1 | Asynchronous clear-to-send input (high = hold) |
| tx_req_i | input | 1 | Transmitter has a character ready to start |
| tx_busy_i | input | 1 | Transmitter is shifting a character |
| tx_start_o | output | 1 | Permission to start the next character |
| stat_rd_i | input | 1 | Status-read strobe |
| ctsic_ie_i | input | 1 | Interrupt mask bit for the CTS-change flag |
| ctsic_o | output | 1 | Sticky CTS-change flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that:
- disable wins over enable;
- a buffer-full pulse always leaves the flag set;
- RTS stays low outside handshaking mode;
- the change flag is sticky and clears only after a read that has no competing edge;
- a busy transmitter is never told to start;
- the interrupt never fires without the flag.

Only the bench scenarios can show the exact two-edge and three-edge latency of the CTS path. The same holds for the ordering when a change and a read arrive together, and for whether random mixes of commands, CTS toggles and mode switches give exactly the RTS and start sequence that the requirements predict.

// File: rtl/fc_pkg.sv
package fc_pkg;
    localparam int MODE_W = 4;
    localparam logic [MODE_W-1:0] MODE_HANDSHAKE = 4'h2;

    typedef struct packed {
        logic rx_on;
        logic buf_full;
    } rx_state_t;

    typedef struct packed {
        logic change;
    } stat_state_t;
endpackage

// File: rtl/fc_cts_sync.sv
module fc_cts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_i,
    output logic level_o,
    output logic edge_o
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [LAST:0] chain;
        logic          prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = cts_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
        s_d.prev = s_q.chain[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign level_o = s_q.chain[LAST];
    assign edge_o  = s_q.chain[LAST] ^ s_q.prev;
endmodule

// File: rtl/fc_rx_ctrl.sv
module fc_rx_ctrl
    import fc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hs_mode_i,
    input  logic en_cmd_i,
    input  logic dis_cmd_i,
    input  logic buf_full_i,
    input  logic rearm_i,
    output logic rx_on_o,
    output logic buf_full_o,
    output logic rts_o
);
    rx_state_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (dis_cmd_i)     r_d.rx_on = 1'b0;
        else if (en_cmd_i) r_d.rx_on = 1'b1;
        if (buf_full_i)    r_d.buf_full = 1'b1;
        else if (rearm_i)  r_d.buf_full = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rx_on_o    = r_q.rx_on;
    assign buf_full_o = r_q.buf_full;
    assign rts_o      = hs_mode_i & (~r_q.rx_on | r_q.buf_full);
endmodule

// File: rtl/fc_cts_status.sv
module fc_cts_status
    import fc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    input  logic rd_i,
    input  logic ie_i,
    output logic flag_o,
    output logic irq_o
);
    stat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (edge_i)    st_d.change = 1'b1;
        else if (rd_i) st_d.change = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.change;
    assign irq_o  = st_q.change & ie_i;
endmodule

// File: rtl/fc_tx_gate.sv
module fc_tx_gate (
    input  logic hs_mode_i,
    input  logic cts_level_i,
    input  logic req_i,
    input  logic busy_i,
    output logic start_o
);
    logic hold;

    always_comb begin
        hold    = hs_mode_i & cts_level_i;
        start_o = req_i & ~busy_i & ~hold;
    end
endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
    import fc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              rx_en_cmd_i,
    input  logic              rx_dis_cmd_i,
    input  logic              dma_buf_full_i,
    input  logic              buf_rearm_i,
    output logic              rts_o,
    output logic              rxbuff_o,
    input  logic              cts_i,
    input  logic              tx_req_i,
    input  logic              tx_busy_i,
    output logic              tx_start_o,
    input  logic              stat_rd_i,
    input  logic              ctsic_ie_i,
    output logic              ctsic_o,
    output logic              irq_o
);
    logic hs_mode;
    logic cts_level;
    logic cts_edge;
    logic rx_on;

    assign hs_mode = (mode_i == MODE_HANDSHAKE);

    fc_cts_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .cts_i(cts_i),
        .level_o(cts_level), .edge_o(cts_edge)
    );

    fc_rx_ctrl i_rx (
        .clk(clk), .rst_n(rst_n), .hs_mode_i(hs_mode),
        .en_cmd_i(rx_en_cmd_i), .dis_cmd_i(rx_dis_cmd_i),
        .buf_full_i(dma_buf_full_i), .rearm_i(buf_rearm_i),
        .rx_on_o(rx_on), .buf_full_o(rxbuff_o), .rts_o(rts_o)
    );

    fc_cts_status i_stat (
        .clk(clk), .rst_n(rst_n), .edge_i(cts_edge), .rd_i(stat_rd_i),
        .ie_i(ctsic_ie_i), .flag_o(ctsic_o), .irq_o(irq_o)
    );

    fc_tx_gate i_gate (
        .hs_mode_i(hs_mode), .cts_level_i(cts_level),
        .req_i(tx_req_i), .busy_i(tx_busy_i), .start_o(tx_start_o)
    );
endmodule

// File: rtl/fc_flow_chk.sv
module fc_flow_chk
    import fc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [MODE_W-1:0] mode_i,
    input logic              rx_dis_cmd_i,
    input logic              dma_buf_full_i,
    input logic              rts_o,
    input logic              rxbuff_o,
    input logic              tx_busy_i,
    input logic              tx_start_o,
    input logic              stat_rd_i,
    input logic              ctsic_o,
    input logic              irq_o,
    input logic              rx_on,
    input logic              cts_edge
);
    // R4
    dis_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dis_cmd_i |=> !rx_on);

    // R5
    buf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_buf_full_i |=> rxbuff_o);

    // R2
    rts_off_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != MODE_HANDSHAKE) |-> !rts_o);

    // R8
    change_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctsic_o && !stat_rd_i) |=> ctsic_o);

    // R9
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && !cts_edge) |=> !ctsic_o);

    // R6
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy_i |-> !tx_start_o);

    // R10
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ctsic_o);
endmodule

bind uart_flow_ctrl fc_flow_chk i_flow_chk (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .rx_dis_cmd_i(rx_dis_cmd_i),
    .dma_buf_full_i(dma_buf_full_i), .rts_o(rts_o), .rxbuff_o(rxbuff_o),
    .tx_busy_i(tx_busy_i), .tx_start_o(tx_start_o), .stat_rd_i(stat_rd_i),
    .ctsic_o(ctsic_o), .irq_o(irq_o), .rx_on(rx_on), .cts_edge(cts_edge)
);

// File: tb/test_uart_flow_ctrl.sv
module test_uart_flow_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] mode = 4'h2;
    logic en = 0, dis = 0, full = 0, rearm = 0, cts = 0;
    logic req = 0, busy = 0, rd = 0, ie = 0;
    logic rts, rxbuff, start, ctsic, irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    uart_flow_ctrl i_uart_flow_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .rx_en_cmd_i(en), .rx_dis_cmd_i(dis), .dma_buf_full_i(full),
        .buf_rearm_i(rearm), .rts_o(rts), .rxbuff_o(rxbuff), .cts_i(cts),
        .tx_req_i(req), .tx_busy_i(busy), .tx_start_o(start),
        .stat_rd_i(rd), .ctsic_ie_i(ie), .ctsic_o(ctsic), .irq_o(irq)
    );

    // behavioural model from the requirements
    logic [1:0] m_sync;
    logic m_prev, m_on, m_buf, m_ic;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sync <= 2'b00; m_prev <= 1'b0; m_on <= 1'b0;
            m_buf <= 1'b0; m_ic <= 1'b0;
        end else begin
            m_sync <= {m_sync[0], cts};
            m_prev <= m_sync[1];
            m_on   <= dis ? 1'b0 : (en ? 1'b1 : m_on);
            m_buf  <= full ? 1'b1 : (rearm ? 1'b0 : m_buf);
            m_ic   <= (m_sync[1] ^ m_prev) ? 1'b1 : (rd ? 1'b0 : m_ic);
        end
    end

    function automatic logic exp_rts();
        return (mode == 4'h2) && (!m_on || m_buf);
    endfunction
    function automatic logic exp_start();
        return req && !busy && ((mode != 4'h2) || !m_sync[1]);
    endfunction
    function automatic logic exp_irq();
        return m_ic && ie;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        check("R3/R5 rts", rts, exp_rts());
        check("R5 rxbuff", rxbuff, m_buf);
        check("R6 tx_start", start, exp_start());
        check("R8/R9 ctsic", ctsic, m_ic);
        check("R10 irq", irq, exp_irq());
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    task automatic clear_pulses();
        en = 0; dis = 0; full = 0; rearm = 0; rd = 0;
    endtask

    initial begin
        #(5 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rts", rts, 1'b1);
        check("R1 rxbuff", rxbuff, 1'b0);
        check("R1 ctsic", ctsic, 1'b0);
        check("R1 irq", irq, 1'b0);
        rst_n = 1'b1;

        // R4 enable and disable together: disable wins, RTS stays high
        en = 1; dis = 1; cycle(); clear_pulses();
        check("R4 both pulses", rts, 1'b1);
        en = 1; cycle(); clear_pulses();
        check("R4 enable", rts, 1'b0);

        // R5 set and rearm together: set wins
        full = 1; rearm = 1; cycle(); clear_pulses();
        check("R5 set priority", rxbuff, 1'b1);
        check("R5 rts on full", rts, 1'b1);
        rearm = 1; cycle(); clear_pulses();
        check("R5 rearm", rts, 1'b0);

        // R7 latency of the CTS path
        req = 1; busy = 0; cts = 1;
        cycle();
        check("R7 start after one edge", start, 1'b1);
        cycle();
        check("R7 start after two edges", start, 1'b0);
        check("R7 flag not yet set", ctsic, 1'b0);
        cycle();
        check("R7 flag after three edges", ctsic, 1'b1);

        // R9 read clears; change and read in the same cycle keep it set
        rd = 1; cycle(); clear_pulses();
        check("R9 read clears", ctsic, 1'b0);
        cts = 0; cycle(); cycle();
        rd = 1; cycle(); clear_pulses();
        check("R9 change beats read", ctsic, 1'b1);

        // R2 outside handshaking mode
        mode = 4'h0; cts = 1; cycle(); cycle(); cycle();
        check("R2 rts low", rts, 1'b0);
        check("R2 cts ignored", start, 1'b1);
        ie = 1; cycle();
        check("R10 irq masked on", irq, ctsic);

        // random phase
        for (int i = 0; i < 6000; i++) begin
            if (($urandom % 300) == 0) mode = (($urandom % 4) == 0) ? 4'($urandom % 16) : 4'h2;
            en    = (($urandom % 16) == 0);
            dis   = (($urandom % 32) == 0);
            full  = (($urandom % 16) == 0);
            rearm = (($urandom % 12) == 0);
            rd    = (($urandom % 6) == 0);
            if (($urandom % 8) == 0) cts = ~cts;
            if (($urandom % 50) == 0) ie = ~ie;
            req  = (($urandom % 2) == 0);
            busy = (($urandom % 3) == 0);
            cycle();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule